// File: doc/BRIEF.md
# Keyed Configuration Data Port

This block lets boot firmware fetch configuration items, and hand some of them back, through two registers. A half-word write to the selector register picks an item by a 16-bit key. Each byte access to the data register then moves one byte of that item, and an internal offset steps forward by one on every access that succeeds. Items live in a small internal table with two banks of equal depth: a generic bank and an architecture-local bank. Each entry carries a length, a present flag, a writable flag and up to `BYTES_PER_ENTRY` bytes of storage.

The key is decoded as follows. Bit 15 requests the write channel. Bit 14 picks the architecture-local bank. The low `IDX_W` bits index an entry within the bank. Bits in between are ignored. An index at or above `MAX_ENTRIES` turns the selection into the reserved invalid key 16'hFFFF. When a write fills a writable entry, the block pulses a completion strobe that names the entry, and the offset rewinds to zero. A preload port fills the table before firmware starts.

Top module: `keyed_cfg_port`

## Requirements
- R1: A selector write (`ctl_wr_i` with `ctl_size_i`=1, half-word) whose index field `ctl_wdata_i[IDX_W-1:0]` is below `MAX_ENTRIES` stores the whole key, sets `sel_found_o` to 1 and sets the offset to 0.
- R2: A selector write whose index field is `MAX_ENTRIES` or more stores the key 16'hFFFF and clears `sel_found_o`. Under that key, reads return 0 and writes are ignored.
- R3: Key bit 14 selects bank 1 (architecture-local) and bit 14 = 0 selects bank 0. The same index in the two banks names two separate entries.
- R4: A byte read (`dat_rd_i` with `dat_size_i`=0) returns 0 on `dat_rdata_o`, without moving the offset, when the entry is not present or the offset is not below its length. Otherwise it returns the byte at the offset and increments the offset. The result is visible after the clock edge that took the read.
- R5: A byte write (`dat_wr_i` with `dat_size_i`=0) is accepted only when the key is valid, key bit 15 is set, the entry is writable and the offset is below the length. An accepted write stores the byte at the offset and increments the offset. Any other write changes neither storage nor offset.
- R6: An accepted write that brings the offset to the length rewinds the offset to 0. After that edge it raises `done_o` for one cycle, with `done_bank_o`/`done_idx_o` naming the entry.
- R7: Reset selects key 0: offset 0, `sel_found_o`=1, `dat_rdata_o`=0, `done_o`=0.
- R8: Bytes stream in ascending storage address order from address 0, so an integer stored little-endian reads out least significant byte first.
- R9: Selector accesses whose size is not half-word (0, 2 or 3) have no effect. Data accesses whose size is not byte (1, 2 or 3) have no effect, and `dat_rdata_o` holds its value.
- R10: A byte read and a byte write in the same cycle perform the write only, and `dat_rdata_o` becomes 0.
- R11: A selector write in the same cycle as a data access performs the select only. If a byte read was requested, `dat_rdata_o` becomes 0.
- R12: The preload port writes one storage byte per `pl_byte_we_i` cycle. On each `pl_attr_we_i` cycle it sets an entry's length, present flag and writable flag. Lengths must not exceed `BYTES_PER_ENTRY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Selector register write strobe |
| ctl_size_i | input | 2 | Selector access size (0 byte, 1 half, 2 word, 3 double) |
| ctl_wdata_i | input | 16 | Key written to the selector |
| dat_wr_i | input | 1 | Data register write strobe |
| dat_rd_i | input | 1 | Data register read strobe |
| dat_size_i | input | 2 | Data access size, same encoding |
| dat_wdata_i | input | 8 | Byte written to the data register |
| dat_rdata_o | output | 8 | Byte returned by the last data read |
| sel_found_o | output | 1 | Last select named an existing index |
| done_o | output | 1 | One-cycle completion strobe for a filled writable entry |
| done_bank_o | output | 1 | Bank of the completed entry |
| done_idx_o | output | IDX_W | Index of the completed entry |
| pl_byte_we_i | input | 1 | Preload storage byte write |
| pl_attr_we_i | input | 1 | Preload entry attribute write |
| pl_bank_i | input | 1 | Preload bank |
| pl_idx_i | input | IDX_W | Preload entry index |
| pl_addr_i | input | log2(BYTES_PER_ENTRY) | Preload byte address |
| pl_data_i | input | 8 | Preload byte |
| pl_len_i | input | LEN_W | Preload entry length |
| pl_present_i | input | 1 | Preload present flag |
| pl_writable_i | input | 1 | Preload writable flag |

## Verification
The assertions check on every cycle the outcome of selector writes: found or invalid key, offset at zero, and no effect from a wrong width. They also check zero data from reads under the invalid key or in read-write conflicts, that a completion strobe follows a data write and leaves the offset at zero, and that preload lengths fit the storage. Only the bench scenarios can show what actually moves through the table. That covers little-endian stream order, bank separation, bytes written through the write channel coming back on later reads, ignored writes leaving the stored data unchanged, and reset returning to key 0 partway through traffic. The bench's reference model follows every access to check those.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;
  localparam int KEY_W    = 16;
  localparam int WCH_BIT  = 15;
  localparam int BANK_BIT = 14;
  localparam logic [KEY_W-1:0] KEY_INVALID = 16'hFFFF;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/keyed_cfg_key_decode.sv
module keyed_cfg_key_decode
  import keyed_cfg_pkg::*;
#(
  parameter int IDX_W       = 3,
  parameter int MAX_ENTRIES = 6
) (
  input  logic [KEY_W-1:0] key_i,
  output logic             bank_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wch_o,
  output logic             in_range_o
);
  logic unused_key_bits;

  assign bank_o     = key_i[BANK_BIT];
  assign wch_o      = key_i[WCH_BIT];
  assign idx_o      = key_i[IDX_W-1:0];
  assign in_range_o = int'(idx_o) < MAX_ENTRIES;
  assign unused_key_bits = ^key_i[BANK_BIT-1:IDX_W];
endmodule

// File: rtl/keyed_cfg_table.sv
module keyed_cfg_table #(
  parameter int IDX_W           = 3,
  parameter int BYTES_PER_ENTRY = 16,
  parameter int LEN_W           = 16,
  localparam int ADDR_W = $clog2(BYTES_PER_ENTRY),
  localparam int ENT_W  = IDX_W + 1,
  localparam int N_ENT  = 2 ** ENT_W
) (
  input  logic              clk_i,
  // preload
  input  logic              pl_byte_we_i,
  input  logic              pl_attr_we_i,
  input  logic [ENT_W-1:0]  pl_ent_i,
  input  logic [ADDR_W-1:0] pl_addr_i,
  input  logic [7:0]        pl_data_i,
  input  logic [LEN_W-1:0]  pl_len_i,
  input  logic              pl_present_i,
  input  logic              pl_writable_i,
  // firmware access, one entry at a time
  input  logic [ENT_W-1:0]  ent_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fw_we_i,
  input  logic [7:0]        fw_data_i,
  output logic [7:0]        rd_byte_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              present_o,
  output logic              writable_o
);
  logic [7:0]       mem_q [N_ENT*BYTES_PER_ENTRY];
  logic [LEN_W-1:0] len_q [N_ENT];
  logic [N_ENT-1:0] present_q;
  logic [N_ENT-1:0] writable_q;

  // table acts as RAM: no reset, firmware write wins a same-cycle collision
  always_ff @(posedge clk_i) begin
    if (pl_byte_we_i) mem_q[{pl_ent_i, pl_addr_i}] <= pl_data_i;
    if (fw_we_i)      mem_q[{ent_i, addr_i}]       <= fw_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (pl_attr_we_i) begin
      len_q[pl_ent_i]      <= pl_len_i;
      present_q[pl_ent_i]  <= pl_present_i;
      writable_q[pl_ent_i] <= pl_writable_i;
    end
  end

  assign rd_byte_o  = mem_q[{ent_i, addr_i}];
  assign len_o      = len_q[ent_i];
  assign present_o  = present_q[ent_i];
  assign writable_o = writable_q[ent_i];
endmodule

// File: rtl/keyed_cfg_cursor.sv
module keyed_cfg_cursor
  import keyed_cfg_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_go_i,
  input  logic [KEY_W-1:0] sel_key_i,
  input  logic             sel_ok_i,
  input  logic             wr_go_i,
  input  logic             rd_go_i,
  // decode of the held key
  input  logic             cur_bank_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic             cur_wch_i,
  input  logic             cur_in_range_i,
  // attributes of the held entry
  input  logic [LEN_W-1:0] ent_len_i,
  input  logic             ent_present_i,
  input  logic             ent_writable_i,
  input  logic [7:0]       ent_byte_i,
  output logic [KEY_W-1:0] cur_key_o,
  output logic [LEN_W-1:0] off_o,
  output logic             fw_we_o,
  output logic             found_o,
  output logic [7:0]       rdata_o,
  output logic             done_o,
  output logic             done_bank_o,
  output logic [IDX_W-1:0] done_idx_o
);
  logic [KEY_W-1:0] key_q;
  logic [LEN_W-1:0] off_q;
  logic             cur_valid, in_bounds, rd_hit, wr_hit, last_byte;

  always_comb begin
    cur_valid = (key_q != KEY_INVALID) && cur_in_range_i;
    in_bounds = off_q < ent_len_i;
    rd_hit    = cur_valid && ent_present_i && in_bounds;
    wr_hit    = cur_valid && cur_wch_i && ent_writable_i && in_bounds;
    last_byte = (off_q + 1'b1) == ent_len_i;
  end

  assign fw_we_o = !sel_go_i && wr_go_i && wr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q       <= '0;
      off_q       <= '0;
      found_o     <= 1'b1;
      rdata_o     <= '0;
      done_o      <= 1'b0;
      done_bank_o <= 1'b0;
      done_idx_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (sel_go_i) begin
        key_q   <= sel_ok_i ? sel_key_i : KEY_INVALID;
        found_o <= sel_ok_i;
        off_q   <= '0;
        if (rd_go_i) rdata_o <= '0;
      end else if (wr_go_i) begin
        if (wr_hit) begin
          if (last_byte) begin
            off_q       <= '0;
            done_o      <= 1'b1;
            done_bank_o <= cur_bank_i;
            done_idx_o  <= cur_idx_i;
          end else begin
            off_q <= off_q + 1'b1;
          end
        end
        if (rd_go_i) rdata_o <= '0;
      end else if (rd_go_i) begin
        if (rd_hit) begin
          rdata_o <= ent_byte_i;
          off_q   <= off_q + 1'b1;
        end else begin
          rdata_o <= '0;
        end
      end
    end
  end

  assign cur_key_o = key_q;
  assign off_o     = off_q;
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_pkg::*;
#(
  parameter int IDX_W           = 3,
  parameter int MAX_ENTRIES     = 6,
  parameter int BYTES_PER_ENTRY = 16,
  parameter int LEN_W           = 16,
  localparam int ADDR_W = $clog2(BYTES_PER_ENTRY),
  localparam int ENT_W  = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [1:0]        ctl_size_i,
  input  logic [15:0]       ctl_wdata_i,
  input  logic              dat_wr_i,
  input  logic              dat_rd_i,
  input  logic [1:0]        dat_size_i,
  input  logic [7:0]        dat_wdata_i,
  output logic [7:0]        dat_rdata_o,
  output logic              sel_found_o,
  output logic              done_o,
  output logic              done_bank_o,
  output logic [IDX_W-1:0]  done_idx_o,
  input  logic              pl_byte_we_i,
  input  logic              pl_attr_we_i,
  input  logic              pl_bank_i,
  input  logic [IDX_W-1:0]  pl_idx_i,
  input  logic [ADDR_W-1:0] pl_addr_i,
  input  logic [7:0]        pl_data_i,
  input  logic [LEN_W-1:0]  pl_len_i,
  input  logic              pl_present_i,
  input  logic              pl_writable_i
);
  logic             sel_go, wr_go, rd_go;
  logic             sel_bank, sel_wch, sel_ok;
  logic [IDX_W-1:0] sel_idx;
  logic [KEY_W-1:0] cur_key_q;
  logic [LEN_W-1:0] off_q;
  logic             cur_bank, cur_wch, cur_in_range;
  logic [IDX_W-1:0] cur_idx;
  logic [LEN_W-1:0] ent_len;
  logic             ent_present, ent_writable, fw_we;
  logic [7:0]       ent_byte;
  logic             unused_sel;

  // only half-word selects and byte data accesses count
  assign sel_go = ctl_wr_i && (ctl_size_i == SZ_HALF);
  assign wr_go  = dat_wr_i && (dat_size_i == SZ_BYTE);
  assign rd_go  = dat_rd_i && (dat_size_i == SZ_BYTE);
  assign unused_sel = sel_bank ^ sel_wch ^ (^sel_idx);

  keyed_cfg_key_decode #(.IDX_W(IDX_W), .MAX_ENTRIES(MAX_ENTRIES)) u_sel_dec (
    .key_i(ctl_wdata_i), .bank_o(sel_bank), .idx_o(sel_idx),
    .wch_o(sel_wch), .in_range_o(sel_ok)
  );

  keyed_cfg_key_decode #(.IDX_W(IDX_W), .MAX_ENTRIES(MAX_ENTRIES)) u_cur_dec (
    .key_i(cur_key_q), .bank_o(cur_bank), .idx_o(cur_idx),
    .wch_o(cur_wch), .in_range_o(cur_in_range)
  );

  keyed_cfg_table #(
    .IDX_W(IDX_W), .BYTES_PER_ENTRY(BYTES_PER_ENTRY), .LEN_W(LEN_W)
  ) u_table (
    .clk_i        (clk_i),
    .pl_byte_we_i (pl_byte_we_i),
    .pl_attr_we_i (pl_attr_we_i),
    .pl_ent_i     ({pl_bank_i, pl_idx_i}),
    .pl_addr_i    (pl_addr_i),
    .pl_data_i    (pl_data_i),
    .pl_len_i     (pl_len_i),
    .pl_present_i (pl_present_i),
    .pl_writable_i(pl_writable_i),
    .ent_i        ({cur_bank, cur_idx}),
    .addr_i       (off_q[ADDR_W-1:0]),
    .fw_we_i      (fw_we),
    .fw_data_i    (dat_wdata_i),
    .rd_byte_o    (ent_byte),
    .len_o        (ent_len),
    .present_o    (ent_present),
    .writable_o   (ent_writable)
  );

  keyed_cfg_cursor #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_cursor (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_go_i      (sel_go),
    .sel_key_i     (ctl_wdata_i),
    .sel_ok_i      (sel_ok),
    .wr_go_i       (wr_go),
    .rd_go_i       (rd_go),
    .cur_bank_i    (cur_bank),
    .cur_idx_i     (cur_idx),
    .cur_wch_i     (cur_wch),
    .cur_in_range_i(cur_in_range),
    .ent_len_i     (ent_len),
    .ent_present_i (ent_present),
    .ent_writable_i(ent_writable),
    .ent_byte_i    (ent_byte),
    .cur_key_o     (cur_key_q),
    .off_o         (off_q),
    .fw_we_o       (fw_we),
    .found_o       (sel_found_o),
    .rdata_o       (dat_rdata_o),
    .done_o        (done_o),
    .done_bank_o   (done_bank_o),
    .done_idx_o    (done_idx_o)
  );
endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk
  import keyed_cfg_pkg::*;
#(
  parameter int IDX_W           = 3,
  parameter int MAX_ENTRIES     = 6,
  parameter int BYTES_PER_ENTRY = 16,
  parameter int LEN_W           = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_wr_i,
  input logic [1:0]       ctl_size_i,
  input logic [15:0]      ctl_wdata_i,
  input logic             dat_wr_i,
  input logic             dat_rd_i,
  input logic [1:0]       dat_size_i,
  input logic [7:0]       dat_rdata_o,
  input logic             sel_found_o,
  input logic             done_o,
  input logic [KEY_W-1:0] cur_key_q,
  input logic [LEN_W-1:0] off_q,
  input logic             pl_attr_we_i,
  input logic [LEN_W-1:0] pl_len_i
);
  logic sel_half, idx_ok, byte_acc;
  assign sel_half = ctl_wr_i && (ctl_size_i == SZ_HALF);
  assign idx_ok   = int'(ctl_wdata_i[IDX_W-1:0]) < MAX_ENTRIES;
  assign byte_acc = dat_size_i == SZ_BYTE;

  a_r1_select_found: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_half && idx_ok |=> cur_key_q == $past(ctl_wdata_i) && sel_found_o && off_q == '0);

  a_r2_select_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_half && !idx_ok |=> cur_key_q == KEY_INVALID && !sel_found_o && off_q == '0);

  a_r2_invalid_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_i && dat_rd_i && byte_acc && cur_key_q == KEY_INVALID |=> dat_rdata_o == 8'h00);

  a_r6_done_rewinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> off_q == '0 && $past(dat_wr_i));

  a_r9_ctl_width_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i && ctl_size_i != SZ_HALF && !dat_wr_i && !dat_rd_i
    |=> $stable(cur_key_q) && $stable(off_q) && $stable(sel_found_o));

  a_r10_conflict_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_rd_i && dat_wr_i && byte_acc |=> dat_rdata_o == 8'h00);

  a_r12_len_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_attr_we_i |-> int'(pl_len_i) <= BYTES_PER_ENTRY);
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
  .IDX_W(IDX_W), .MAX_ENTRIES(MAX_ENTRIES),
  .BYTES_PER_ENTRY(BYTES_PER_ENTRY), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/keyed_cfg_port_tb.sv
`timescale 1ns/1ps
module keyed_cfg_port_tb;
  localparam int IDX_W = 3;
  localparam int MAXE  = 6;
  localparam int NB    = 16;
  localparam int LEN_W = 16;
  localparam int NI    = 2 ** IDX_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic ctl_wr = 0, dat_wr = 0, dat_rd = 0;
  logic [1:0] ctl_size = 0, dat_size = 0;
  logic [15:0] ctl_wdata = 0;
  logic [7:0] dat_wdata = 0, dat_rdata;
  logic sel_found, done, done_bank;
  logic [IDX_W-1:0] done_idx;
  logic pl_byte_we = 0, pl_attr_we = 0, pl_bank = 0, pl_present = 0, pl_writable = 0;
  logic [IDX_W-1:0] pl_idx = 0;
  logic [3:0] pl_addr = 0;
  logic [7:0] pl_data = 0;
  logic [LEN_W-1:0] pl_len = 0;

  keyed_cfg_port #(.IDX_W(IDX_W), .MAX_ENTRIES(MAXE), .BYTES_PER_ENTRY(NB), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_wr_i(ctl_wr), .ctl_size_i(ctl_size), .ctl_wdata_i(ctl_wdata),
    .dat_wr_i(dat_wr), .dat_rd_i(dat_rd), .dat_size_i(dat_size), .dat_wdata_i(dat_wdata),
    .dat_rdata_o(dat_rdata), .sel_found_o(sel_found), .done_o(done), .done_bank_o(done_bank),
    .done_idx_o(done_idx), .pl_byte_we_i(pl_byte_we), .pl_attr_we_i(pl_attr_we), .pl_bank_i(pl_bank),
    .pl_idx_i(pl_idx), .pl_addr_i(pl_addr), .pl_data_i(pl_data), .pl_len_i(pl_len),
    .pl_present_i(pl_present), .pl_writable_i(pl_writable)
  );

  // reference model
  logic [7:0] m_mem [2][NI][NB];
  int         m_len [2][NI];
  logic       m_pres [2][NI];
  logic       m_wrt [2][NI];
  logic [15:0] m_key;
  int          m_off;
  logic        m_found;
  logic [7:0]  m_rd;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pl_attr(input int b, input int i, input int len, input bit p, input bit w);
    pl_attr_we = 1; pl_bank = b[0]; pl_idx = i[IDX_W-1:0]; pl_len = len[LEN_W-1:0];
    pl_present = p; pl_writable = w;
    @(negedge clk);
    pl_attr_we = 0;
    m_len[b][i] = len; m_pres[b][i] = p; m_wrt[b][i] = w;
  endtask

  task automatic pl_byte(input int b, input int i, input int a, input logic [7:0] d);
    pl_byte_we = 1; pl_bank = b[0]; pl_idx = i[IDX_W-1:0]; pl_addr = a[3:0]; pl_data = d;
    @(negedge clk);
    pl_byte_we = 0;
    m_mem[b][i][a] = d;
  endtask

  // one bus cycle: model first, drive across one rising edge, then compare
  task automatic op(input logic cw, input logic [1:0] csz, input logic [15:0] cd,
                    input logic dw, input logic dr, input logic [1:0] dsz, input logic [7:0] wd);
    bit sel, wr, rd, v, exp_done;
    int b, i;
    string rtag;
    exp_done = 0; b = 0; i = 0;
    rtag = "R9";
    sel = cw && csz == 2'd1;
    wr  = dw && dsz == 2'd0;
    rd  = dr && dsz == 2'd0;
    b = int'(m_key[14]); i = int'(m_key[2:0]);
    v = (m_key != 16'hFFFF) && (i < MAXE);
    if (sel) begin
      m_found = int'(cd[2:0]) < MAXE;
      m_key = m_found ? cd : 16'hFFFF;
      m_off = 0;
      if (rd) begin m_rd = 0; rtag = "R11"; end
    end else if (wr) begin
      if (v && m_key[15] && m_wrt[b][i] && m_off < m_len[b][i]) begin
        m_mem[b][i][m_off] = wd;
        m_off++;
        if (m_off == m_len[b][i]) begin m_off = 0; exp_done = 1; end
      end
      if (rd) begin m_rd = 0; rtag = "R10"; end
    end else if (rd) begin
      if (v && m_pres[b][i] && m_off < m_len[b][i]) begin
        m_rd = m_mem[b][i][m_off]; m_off++; rtag = "R4";
      end else begin
        m_rd = 0; rtag = v ? "R4" : "R2";
      end
    end
    ctl_wr = cw; ctl_size = csz; ctl_wdata = cd;
    dat_wr = dw; dat_rd = dr; dat_size = dsz; dat_wdata = wd;
    @(negedge clk);
    ctl_wr = 0; dat_wr = 0; dat_rd = 0; ctl_size = 0; dat_size = 0;
    chk(rtag, "rdata", dat_rdata, m_rd);
    chk(sel ? (m_found ? "R1" : "R2") : "R9", "found", sel_found, m_found);
    chk(exp_done ? "R6" : "R5", "done", done, exp_done);
    if (exp_done) begin
      chk("R6", "done_bank", done_bank, b);
      chk("R6", "done_idx", done_idx, i);
    end
  endtask

  task automatic sel_key(input logic [15:0] k);
    op(1, 2'd1, k, 0, 0, 2'd0, 8'h00);
  endtask
  task automatic rd_byte();
    op(0, 2'd0, 16'h0, 0, 1, 2'd0, 8'h00);
  endtask
  task automatic wr_byte(input logic [7:0] d);
    op(0, 2'd0, 16'h0, 1, 0, 2'd0, d);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    m_key = 0; m_off = 0; m_found = 1; m_rd = 0;
    @(negedge clk);
    chk("R7", "found after reset", sel_found, 1);
    chk("R7", "rdata after reset", dat_rdata, 0);
    chk("R7", "done after reset", done, 0);
  endtask

  initial begin
    logic [31:0] word;
    void'($urandom(32'd7331));
    m_key = 0; m_off = 0; m_found = 1; m_rd = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R7", "found after reset", sel_found, 1);
    chk("R7", "rdata after reset", dat_rdata, 0);
    chk("R7", "done after reset", done, 0);

    // R12 preload: random table, then directed entries
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NI; i++) begin
        pl_attr(b, i, int'($urandom % (NB + 1)), ($urandom % 4) != 0, $urandom % 2);
        for (int a = 0; a < NB; a++) pl_byte(b, i, a, 8'($urandom));
      end
    pl_attr(0, 0, 4, 1, 0);
    pl_byte(0, 0, 0, 8'h78); pl_byte(0, 0, 1, 8'h56); pl_byte(0, 0, 2, 8'h34); pl_byte(0, 0, 3, 8'h12);
    pl_attr(1, 0, 4, 1, 0);
    pl_byte(1, 0, 0, 8'hAA); pl_byte(1, 0, 1, 8'hBB);
    pl_attr(0, 2, 3, 1, 1);
    pl_attr(0, 3, 5, 0, 0);

    // R8 little-endian stream order from key 0 selected by reset
    word = 0;
    for (int k = 0; k < 4; k++) begin rd_byte(); word[8*k +: 8] = dat_rdata; end
    chk("R8", "LE word", word, 32'h12345678);
    rd_byte();
    chk("R4", "read past length", dat_rdata, 0);

    // R3 bank bit
    sel_key(16'h4000); rd_byte();
    chk("R3", "bank1 idx0 first byte", dat_rdata, 8'hAA);
    sel_key(16'h0000); rd_byte();
    chk("R3", "bank0 idx0 first byte", dat_rdata, 8'h78);

    // R2 invalid index
    sel_key(16'h0006);
    chk("R2", "found on bad index", sel_found, 0);
    rd_byte();
    op(0, 2'd0, 16'h0, 1, 0, 2'd0, 8'h5A);

    // R9 wrong-width select ignored
    sel_key(16'h0000);
    op(1, 2'd2, 16'h4000, 0, 0, 2'd0, 8'h00);
    op(1, 2'd0, 16'h4000, 0, 0, 2'd0, 8'h00);
    rd_byte();
    chk("R9", "key kept after bad width", dat_rdata, 8'h78);
    op(0, 2'd0, 16'h0, 0, 1, 2'd1, 8'h00);

    // R5 R6 write channel fill then read back
    sel_key(16'h8002);
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33);
    rd_byte(); chk("R5", "written byte 0", dat_rdata, 8'h11);
    rd_byte(); rd_byte(); chk("R5", "written byte 2", dat_rdata, 8'h33);
    sel_key(16'h0002); wr_byte(8'hEE); rd_byte();
    chk("R5", "write without channel bit ignored", dat_rdata, 8'h11);

    // R10 conflict, R11 select with read
    sel_key(16'h8002);
    op(0, 2'd0, 16'h0, 1, 1, 2'd0, 8'h44);
    chk("R10", "conflict read", dat_rdata, 0);
    op(1, 2'd1, 16'h0000, 0, 1, 2'd0, 8'h00);
    chk("R11", "select with read", dat_rdata, 0);

    // R4 absent entry
    sel_key(16'h0003); rd_byte();
    chk("R4", "absent entry", dat_rdata, 0);

    // random traffic with a reset in the middle
    for (int pass = 0; pass < 2; pass++) begin
      for (int n = 0; n < 3000; n++) begin
        int r;
        logic [15:0] k;
        logic [1:0] bad;
        r = int'($urandom % 100);
        k = 16'($urandom); k[2:0] = 3'($urandom % NI);
        bad = 2'($urandom % 3); if (bad == 2'd1) bad = 2'd3;
        if (r < 18)      sel_key(k);
        else if (r < 50) rd_byte();
        else if (r < 78) wr_byte(8'($urandom));
        else if (r < 84) op(1, bad, k, 0, 0, 2'd0, 8'h00);
        else if (r < 90) op(0, 2'd0, 16'h0, 1'($urandom), 1'($urandom), 2'(1 + $urandom % 3), 8'($urandom));
        else if (r < 95) op(0, 2'd0, 16'h0, 1, 1, 2'd0, 8'($urandom));
        else             op(1, 2'd1, k, 0, 1, 2'd0, 8'h00);
      end
      if (pass == 0) begin
        do_reset();
        rd_byte();
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule